// File: doc/BRIEF.md
# Flash Word Program-and-Verify Sequencer

This block writes a run of consecutive words into a parallel NOR-style flash device, one word at a time. It takes each word from a streaming data source and sends the three-write unlock-and-program command sequence. It then writes the word to its target address. After that it keeps reading the target location until the device's toggle-free completion bit says the internal program cycle has finished. A final read of the word is compared with the intended value.

A word that verifies moves the address up by one and the loop continues. When the last word has verified, the block gives a one-cycle completion pulse. A readback mismatch, or a status poll that never reports completion within a bounded number of cycles, stops the loop. In that case the block raises a sticky fault flag and records the address that failed.

The flash bus uses single-cycle strobes. A write is one cycle of `fl_we` with address and data valid. A read is one cycle of `fl_oe`, and the device presents the read data from the following cycle onward.

Top module: `flash_pgm_loop`

## Requirements
- R1: After reset `done`, `err` and `err_addr` are zero and neither `fl_we` nor `fl_oe` is asserted until `start`.
- R2: For every word the bus sees exactly four writes in this order: 0x00AA to address 0x555, 0x0055 to address 0x2AA, 0x00A0 to address 0x555, then the data word to its target address. A read strobe and a write strobe are never asserted together.
- R3: While the device is busy, bit 7 of a status read at the target address is the complement of bit 7 of the written word. The block keeps polling until bit 7 of the read equals bit 7 of the data, and only then performs the verify read.
- R4: If the verify read differs from the intended word in any bit, `err` rises, `err_addr` holds that word's address, and no further bus writes occur.
- R5: If polling has not shown completion after `POLL_LIMIT` cycles of polling, `err` rises with `err_addr` set to the word's address, no earlier than `POLL_LIMIT` cycles after the data write.
- R6: Words go to `base_addr`, `base_addr+1`, … up to `word_count` words. `done` is high for exactly one cycle after the last word verifies, and never together with `err`.
- R7: A `start` with `word_count` of zero pulses `done` and makes no bus access.
- R8: `start` is ignored while a run is in progress.
- R9: One source word is consumed per address, only in a cycle where `src_valid` and `src_ready` are both high. `err` stays high until the next accepted `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| base_addr | input | AW | First target word address |
| word_count | input | AW | Number of words to program |
| src_valid | input | 1 | Source word available |
| src_data | input | DW | Source word |
| src_ready | output | 1 | Block takes the source word this cycle |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data, valid the cycle after `fl_oe` |
| fl_we | output | 1 | One-cycle write strobe |
| fl_oe | output | 1 | One-cycle read strobe |
| done | output | 1 | One-cycle pulse: all words verified |
| err | output | 1 | Sticky fault: verify mismatch or poll timeout |
| err_addr | output | AW | Address of the failing word |

## Verification
Runs are made with an always-ready source and with a source that stalls every other pair of cycles. Together they show that word capture depends on the handshake rather than on a fixed schedule. The device model's busy time varies with the address. A sequencer that verified early, or judged completion on anything other than bit 7, would read back the inverted status word and flag a false mismatch.

A stuck bit at one address and a never-finishing program at another separate the two fault paths. Their recorded addresses and their timing relative to the last data write are compared. Zero-length runs, restarts attempted mid-run and a clean run after a fault cover the control corners.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CMD,
        ST_POLL,
        ST_VERIFY
    } ctl_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_STROBE,
        PH_CAPTURE
    } port_phase_e;

    localparam logic [11:0] UNLOCK_ADDR_A = 12'h555;
    localparam logic [11:0] UNLOCK_ADDR_B = 12'h2AA;
    localparam logic [7:0]  UNLOCK_DATA_A = 8'hAA;
    localparam logic [7:0]  UNLOCK_DATA_B = 8'h55;
    localparam logic [7:0]  PROGRAM_CODE  = 8'hA0;
    localparam int          POLL_BIT      = 7;
endpackage

// File: rtl/pgm_bus_port.sv
module pgm_bus_port
    import pgm_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          rsp,
    output logic [DW-1:0] rsp_data,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic [DW-1:0] fl_rdata,
    output logic          fl_we,
    output logic          fl_oe
);
    typedef struct packed {
        port_phase_e   ph;
        logic          we;
        logic          oe;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          rsp;
        logic [DW-1:0] rdata;
    } port_s;

    port_s p_d, p_q;

    always_comb begin
        p_d     = p_q;
        p_d.rsp = 1'b0;
        p_d.we  = 1'b0;
        p_d.oe  = 1'b0;
        unique case (p_q.ph)
            PH_IDLE: if (req) begin
                p_d.ph    = PH_STROBE;
                p_d.we    = req_wr;
                p_d.oe    = !req_wr;
                p_d.addr  = req_addr;
                p_d.wdata = req_data;
            end
            PH_STROBE:  p_d.ph = PH_CAPTURE;
            PH_CAPTURE: begin
                p_d.ph    = PH_IDLE;
                p_d.rsp   = 1'b1;
                p_d.rdata = fl_rdata;
            end
            default:    p_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign rsp      = p_q.rsp;
    assign rsp_data = p_q.rdata;
    assign fl_addr  = p_q.addr;
    assign fl_wdata = p_q.wdata;
    assign fl_we    = p_q.we;
    assign fl_oe    = p_q.oe;

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_oe)); // R2
    AST_REQ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (p_q.ph == PH_IDLE)); // R2
endmodule

// File: rtl/pgm_poll_timer.sv
module pgm_poll_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                                  cnt_d = '0;
        else if (run && (cnt_q != CW'(LIMIT)))   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == CW'(LIMIT));

    AST_TMR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT)); // R5
    AST_TMR_EXPIRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clr) |=> expired); // R5
endmodule

// File: rtl/flash_pgm_loop.sv
module flash_pgm_loop
    import pgm_pkg::*;
#(
    parameter int AW         = 12,
    parameter int DW         = 16,
    parameter int POLL_LIMIT = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] word_count,
    input  logic          src_valid,
    input  logic [DW-1:0] src_data,
    output logic          src_ready,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic [DW-1:0] fl_rdata,
    output logic          fl_we,
    output logic          fl_oe,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] err_addr
);
    localparam logic [AW-1:0] ADDR_A = AW'(UNLOCK_ADDR_A);
    localparam logic [AW-1:0] ADDR_B = AW'(UNLOCK_ADDR_B);
    localparam logic [DW-1:0] DATA_A = DW'(UNLOCK_DATA_A);
    localparam logic [DW-1:0] DATA_B = DW'(UNLOCK_DATA_B);
    localparam logic [DW-1:0] DATA_P = DW'(PROGRAM_CODE);

    typedef struct packed {
        ctl_state_e    st;
        logic [1:0]    step;
        logic          pend;
        logic [AW-1:0] addr;
        logic [AW-1:0] left;
        logic [DW-1:0] word;
        logic          done;
        logic          err;
        logic [AW-1:0] err_addr;
    } ctl_s;

    ctl_s c_d, c_q;

    logic          req, req_wr, rsp, tmr_clr, tmr_run, tmr_exp;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data, rsp_data;

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        req       = 1'b0;
        req_wr    = 1'b0;
        req_addr  = c_q.addr;
        req_data  = c_q.word;
        src_ready = 1'b0;
        tmr_clr   = 1'b0;
        tmr_run   = 1'b0;
        unique case (c_q.st)
            ST_IDLE: if (start) begin
                c_d.err  = 1'b0;
                c_d.addr = base_addr;
                c_d.left = word_count;
                if (word_count == '0) c_d.done = 1'b1;
                else                  c_d.st   = ST_FETCH;
            end
            ST_FETCH: begin
                src_ready = 1'b1;
                if (src_valid) begin
                    c_d.word = src_data;
                    c_d.step = 2'd0;
                    c_d.st   = ST_CMD;
                end
            end
            ST_CMD: begin
                if (!c_q.pend) begin
                    req    = 1'b1;
                    req_wr = 1'b1;
                    unique case (c_q.step)
                        2'd0:    begin req_addr = ADDR_A; req_data = DATA_A; end
                        2'd1:    begin req_addr = ADDR_B; req_data = DATA_B; end
                        2'd2:    begin req_addr = ADDR_A; req_data = DATA_P; end
                        default: begin req_addr = c_q.addr; req_data = c_q.word; end
                    endcase
                    c_d.pend = 1'b1;
                end else if (rsp) begin
                    c_d.pend = 1'b0;
                    if (c_q.step == 2'd3) begin
                        c_d.st  = ST_POLL;
                        tmr_clr = 1'b1;
                    end else begin
                        c_d.step = c_q.step + 2'd1;
                    end
                end
            end
            ST_POLL: begin
                tmr_run = 1'b1;
                if (!c_q.pend) begin
                    req      = 1'b1;
                    c_d.pend = 1'b1;
                end else if (rsp) begin
                    c_d.pend = 1'b0;
                    if (rsp_data[POLL_BIT] == c_q.word[POLL_BIT]) begin
                        c_d.st = ST_VERIFY;
                    end else if (tmr_exp) begin
                        c_d.err      = 1'b1;
                        c_d.err_addr = c_q.addr;
                        c_d.st       = ST_IDLE;
                    end
                end
            end
            ST_VERIFY: begin
                if (!c_q.pend) begin
                    req      = 1'b1;
                    c_d.pend = 1'b1;
                end else if (rsp) begin
                    c_d.pend = 1'b0;
                    if (rsp_data != c_q.word) begin
                        c_d.err      = 1'b1;
                        c_d.err_addr = c_q.addr;
                        c_d.st       = ST_IDLE;
                    end else if (c_q.left == AW'(1)) begin
                        c_d.done = 1'b1;
                        c_d.st   = ST_IDLE;
                    end else begin
                        c_d.addr = c_q.addr + 1'b1;
                        c_d.left = c_q.left - 1'b1;
                        c_d.st   = ST_FETCH;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    pgm_bus_port #(.AW(AW), .DW(DW)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_wr   (req_wr),
        .req_addr (req_addr),
        .req_data (req_data),
        .rsp      (rsp),
        .rsp_data (rsp_data),
        .fl_addr  (fl_addr),
        .fl_wdata (fl_wdata),
        .fl_rdata (fl_rdata),
        .fl_we    (fl_we),
        .fl_oe    (fl_oe)
    );

    pgm_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .run     (tmr_run),
        .expired (tmr_exp)
    );

    assign done     = c_q.done;
    assign err      = c_q.err;
    assign err_addr = c_q.err_addr;

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_DONE_NOT_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !err); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err); // R9
    AST_NO_WRITE_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> !fl_we); // R4
endmodule

// File: tb/sim_flash_pgm_loop.sv
module sim_flash_pgm_loop;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int PL = 40;
    localparam logic [AW-1:0] NONE = 12'hFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0, word_count = '0;
    logic          src_valid, src_ready;
    logic [DW-1:0] src_data, fl_wdata, fl_rdata;
    logic [AW-1:0] fl_addr, err_addr;
    logic          fl_we, fl_oe, done, err;

    always #10 clk = ~clk;

    flash_pgm_loop #(.AW(AW), .DW(DW), .POLL_LIMIT(PL)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .word_count(word_count), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata), .fl_we(fl_we), .fl_oe(fl_oe), .done(done),
        .err(err), .err_addr(err_addr)
    );

    int n_checks = 0, n_errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- data source ----------------
    logic [DW-1:0] words [0:15];
    int   idx = 0;
    logic idx_clr = 1'b0;
    logic stall_on = 1'b0;
    logic [3:0] tick = '0;
    always @(posedge clk) begin
        tick <= tick + 1'b1;
        if (idx_clr) idx <= 0;
        else if (src_valid && src_ready) idx <= idx + 1;
    end
    assign src_valid = stall_on ? tick[1] : 1'b1;
    assign src_data  = words[idx[3:0]];

    // ---------------- flash model ----------------
    logic [DW-1:0] mem [0:255];
    logic [DW-1:0] pd = '0, rd_q = '0;
    logic [AW-1:0] pa = '0;
    logic [AW-1:0] hang_addr = NONE, stuck_addr = NONE;
    int   busy = 0;
    logic [1:0] uc = '0;
    always @(posedge clk) begin
        if (fl_we) begin
            case (uc)
                2'd0: uc <= (fl_addr == 12'h555 && fl_wdata == 16'h00AA) ? 2'd1 : 2'd0;
                2'd1: uc <= (fl_addr == 12'h2AA && fl_wdata == 16'h0055) ? 2'd2 : 2'd0;
                2'd2: uc <= (fl_addr == 12'h555 && fl_wdata == 16'h00A0) ? 2'd3 : 2'd0;
                default: begin
                    pd   <= fl_wdata;
                    pa   <= fl_addr;
                    busy <= (fl_addr == hang_addr) ? (1 << 30) : 3 + int'(fl_addr[2:0]);
                    uc   <= 2'd0;
                end
            endcase
        end else if (busy > 0) begin
            busy <= busy - 1;
            if (busy == 1) mem[pa[7:0]] <= (pa == stuck_addr) ? (pd | 16'h0001) : pd;
        end
        if (fl_oe) rd_q <= (busy > 0) ? ~pd : mem[fl_addr[7:0]];
    end
    assign fl_rdata = rd_q;

    // ---------------- scoreboard monitor ----------------
    typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;
    wr_t sb_q[$];
    int cyc = 0, last_we = 0, err_cyc = 0, done_cnt = 0;
    logic err_prev = 1'b0;
    always @(negedge clk) begin
        wr_t e;
        cyc++;
        if (rst_n) begin
            if (fl_we) begin
                last_we = cyc;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected write", {fl_addr, fl_wdata}, 0);
                end else begin
                    e = sb_q.pop_front();
                    chk(fl_addr == e.a && fl_wdata == e.d, "R2", "write addr/data",
                        {fl_addr, fl_wdata}, {e.a, e.d});
                end
            end
            if (fl_we && fl_oe) chk(1'b0, "R2", "dual strobe", 1, 0);
            if (done) begin
                done_cnt++;
                chk(!err, "R6", "done with err", err, 0);
            end
            if (err && !err_prev) err_cyc = cyc;
            err_prev = err;
        end
    end

    function automatic logic [DW-1:0] mk(input int i, input logic [AW-1:0] b);
        logic [DW-1:0] h;
        h = (DW'(b) * 16'h003B) + (DW'(i) * 16'h09D7) ^ 16'h5A5A;
        return {h[DW-1:1], 1'b0};
    endfunction

    // driver: pushes expected writes, launches one run, waits for the outcome
    task automatic run(input logic [AW-1:0] b, input int len, input bit stall,
                       input int n_prog, input bit restart);
        stall_on = stall;
        for (int i = 0; i < 16; i++) words[i] = (i < len) ? mk(i, b) : 16'hDEAD;
        for (int i = 0; i < n_prog; i++) begin
            sb_q.push_back('{12'h555, 16'h00AA});
            sb_q.push_back('{12'h2AA, 16'h0055});
            sb_q.push_back('{12'h555, 16'h00A0});
            sb_q.push_back('{b + AW'(i), words[i]});
        end
        idx_clr = 1'b1;
        @(negedge clk);
        idx_clr = 1'b0;
        done_cnt = 0;
        base_addr = b; word_count = AW'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b0, "R9", "err cleared by start", err, 0);
        if (restart) begin
            repeat (20) @(negedge clk);
            base_addr = 12'h0C0; word_count = 12'd2; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int k = 0; k < 3000; k++) begin
            if (done_cnt > 0 || err) break;
            @(negedge clk);
        end
        repeat (6) @(negedge clk);
        chk(sb_q.size() == 0, "R2", "pending expected writes", sb_q.size(), 0);
        sb_q.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!done && !err && err_addr == '0, "R1", "outputs in reset", {done, err, err_addr}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!fl_we && !fl_oe, "R1", "bus idle after reset", {fl_we, fl_oe}, 0);

        // R3 R6: plain run, address-dependent busy time
        run(12'h010, 4, 1'b0, 4, 1'b0);
        chk(done_cnt == 1, "R6", "done pulse count", done_cnt, 1);
        chk(err == 0, "R3", "no false verify fail", err, 0);
        chk(idx == 4, "R9", "source words taken", idx, 4);

        // R9: stalling source
        run(12'h040, 6, 1'b1, 6, 1'b0);
        chk(done_cnt == 1, "R9", "done with stalled source", done_cnt, 1);
        chk(idx == 6, "R9", "stalled source words taken", idx, 6);

        // R7: zero-length run
        run(12'h050, 0, 1'b0, 0, 1'b0);
        chk(done_cnt == 1, "R7", "zero length done", done_cnt, 1);
        chk(idx == 0, "R7", "zero length no source", idx, 0);

        // R8: restart attempt ignored mid-run
        run(12'h060, 3, 1'b0, 3, 1'b1);
        chk(done_cnt == 1, "R8", "single done despite restart", done_cnt, 1);
        chk(idx == 3, "R8", "restart took no words", idx, 3);

        // R4: stuck bit at third word
        stuck_addr = 12'h082;
        run(12'h080, 4, 1'b0, 3, 1'b0);
        chk(err == 1'b1, "R4", "mismatch err", err, 1);
        chk(err_addr == 12'h082, "R4", "mismatch address", err_addr, 12'h082);
        chk(done_cnt == 0, "R4", "no done on mismatch", done_cnt, 0);
        stuck_addr = NONE;

        // R5: program never completes on second word
        hang_addr = 12'h0A1;
        run(12'h0A0, 3, 1'b0, 2, 1'b0);
        chk(err == 1'b1, "R5", "timeout err", err, 1);
        chk(err_addr == 12'h0A1, "R5", "timeout address", err_addr, 12'h0A1);
        chk(err_cyc - last_we >= PL, "R5", "timeout not early", err_cyc - last_we, PL);
        hang_addr = NONE;
        busy = 0;

        // R9: clean run after a fault clears err
        run(12'h0B0, 2, 1'b0, 2, 1'b0);
        chk(err == 1'b0 && done_cnt == 1, "R9", "recovered run", {err, done_cnt[7:0]}, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule